// File: doc/BRIEF.md
# Packed Media Arithmetic Unit

This block is a single-cycle packed integer execution stage for media datapaths. It takes two packed operands of `DATA_W` bits (64 by default) and a 3-bit operation code, and produces one packed result. The operand is split into unsigned 8-bit lanes or 16-bit lanes, depending on the operation. Each lane is computed on its own, and the lanes are then joined back into a result of the same width.

The supported operations are:
- a rounded-up average on bytes or on words;
- a signed word maximum and minimum;
- an unsigned byte maximum and minimum;
- the upper half of an unsigned 16x16 product on each word.

A byte clamp into a closed range is two passes: a maximum against a floor, then a minimum against a ceiling.

The request side uses a valid/ready handshake. The result side is a registered output with valid, and the consumer acknowledges it with a ready. The result is available one clock after the request is accepted.

Top module: `pma_unit`

## Requirements
- R1: Opcode 0 (byte average) returns, in every 8-bit lane i, (a[i] + b[i] + 1) >> 1 computed without loss of the carry. Average of 10 and 20 is 15, and average of 10 and 21 is 16.
- R2: Opcode 1 (word average) returns, in every 16-bit lane, (a + b + 1) >> 1 on unsigned values with a 17-bit intermediate.
- R3: Opcodes 2 (word maximum) and 4 (word minimum) compare each 16-bit lane as a two's-complement signed value, so 0x8000 is below 0x7FFF.
- R4: Opcodes 3 (byte maximum) and 5 (byte minimum) compare each 8-bit lane as unsigned, so 0x80 is above 0x7F. Maximum with 16 followed by minimum with 235 puts every byte into 16..235.
- R5: Opcode 6 (multiply high) returns bits 31:16 of the unsigned 32-bit product of each pair of 16-bit lanes. 60000 times 32768 gives 30000.
- R6: Opcode 7 produces an all-zero result.
- R7: A request is accepted on a rising edge where both req_valid_i and req_ready_o are high. Its result is shown on res_data_o with res_valid_o high from that edge onward.
- R8: req_ready_o is high when the output holds no result, or when the held result is being taken (res_ready_i high). While a result is held and not taken, res_data_o and res_valid_o stay unchanged, and no request is accepted.
- R9: While rst_ni is low, res_valid_o is low. A taken result with no new request leaves res_valid_o low on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Request can be accepted this cycle |
| req_op_i | input | 3 | Operation code (0..7) |
| req_a_i | input | DATA_W | First packed operand |
| req_b_i | input | DATA_W | Second packed operand |
| res_valid_o | output | 1 | Result register holds a result |
| res_ready_i | input | 1 | Consumer takes the result |
| res_data_o | output | DATA_W | Packed result |

## Verification
The bench builds the unit with DATA_W = 16, which gives two byte lanes and one word lane. At this width, a full sweep of one byte lane against a spread of the other lane's values fits easily in the run. So does a square grid of signed and unsigned boundary words, such as 0x7FFF, 0x8000, 0xFFFF and 0x0001, for every opcode. Carry-out averages, sign-crossing comparisons and the largest products are therefore all reached, together with the stall and back-to-back handshake cases.

// File: rtl/pma_pkg.sv
package pma_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned OP_W   = 3;

  typedef enum logic [OP_W-1:0] {
    OP_AVG_B  = 3'd0,
    OP_AVG_W  = 3'd1,
    OP_MAX_SW = 3'd2,
    OP_MAX_UB = 3'd3,
    OP_MIN_SW = 3'd4,
    OP_MIN_UB = 3'd5,
    OP_MULH_W = 3'd6,
    OP_NONE   = 3'd7
  } pma_op_e;
endpackage

// File: rtl/pma_byte_lane.sv
module pma_byte_lane
  import pma_pkg::*;
(
  input  logic [BYTE_W-1:0] a_i,
  input  logic [BYTE_W-1:0] b_i,
  input  pma_op_e           op_i,
  output logic [BYTE_W-1:0] res_o
);
  logic [BYTE_W:0]   sum;
  logic              a_gt;

  assign sum  = {1'b0, a_i} + {1'b0, b_i} + {{BYTE_W{1'b0}}, 1'b1};
  assign a_gt = a_i > b_i;

  // zero for any opcode that is not a byte operation
  always_comb begin
    unique case (op_i)
      OP_AVG_B:  res_o = sum[BYTE_W:1];
      OP_MAX_UB: res_o = a_gt ? a_i : b_i;
      OP_MIN_UB: res_o = a_gt ? b_i : a_i;
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/pma_word_lane.sv
module pma_word_lane
  import pma_pkg::*;
(
  input  logic [WORD_W-1:0] a_i,
  input  logic [WORD_W-1:0] b_i,
  input  pma_op_e           op_i,
  output logic [WORD_W-1:0] res_o
);
  localparam int unsigned PROD_W = 2 * WORD_W;

  logic [WORD_W:0]   sum;
  logic [PROD_W-1:0] prod;
  logic              a_gt_s;

  assign sum    = {1'b0, a_i} + {1'b0, b_i} + {{WORD_W{1'b0}}, 1'b1};
  assign prod   = {{WORD_W{1'b0}}, a_i} * {{WORD_W{1'b0}}, b_i};
  assign a_gt_s = $signed(a_i) > $signed(b_i);

  always_comb begin
    unique case (op_i)
      OP_AVG_W:  res_o = sum[WORD_W:1];
      OP_MAX_SW: res_o = a_gt_s ? a_i : b_i;
      OP_MIN_SW: res_o = a_gt_s ? b_i : a_i;
      OP_MULH_W: res_o = prod[PROD_W-1:WORD_W];
      default:   res_o = '0;
    endcase
  end
endmodule

// File: rtl/pma_unit.sv
module pma_unit
  import pma_pkg::*;
#(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [OP_W-1:0]   req_op_i,
  input  logic [DATA_W-1:0] req_a_i,
  input  logic [DATA_W-1:0] req_b_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [DATA_W-1:0] res_data_o
);
  localparam int unsigned N_BYTES = DATA_W / BYTE_W;
  localparam int unsigned N_WORDS = DATA_W / WORD_W;

  pma_op_e           op;
  logic [DATA_W-1:0] byte_vec;
  logic [DATA_W-1:0] word_vec;
  logic [DATA_W-1:0] next_res;
  logic              accept;

  assign op = pma_op_e'(req_op_i);

  for (genvar i = 0; i < N_BYTES; i++) begin : g_byte
    pma_byte_lane u_lane (
      .a_i   (req_a_i[i*BYTE_W +: BYTE_W]),
      .b_i   (req_b_i[i*BYTE_W +: BYTE_W]),
      .op_i  (op),
      .res_o (byte_vec[i*BYTE_W +: BYTE_W])
    );
  end

  for (genvar j = 0; j < N_WORDS; j++) begin : g_word
    pma_word_lane u_lane (
      .a_i   (req_a_i[j*WORD_W +: WORD_W]),
      .b_i   (req_b_i[j*WORD_W +: WORD_W]),
      .op_i  (op),
      .res_o (word_vec[j*WORD_W +: WORD_W])
    );
  end

  // byte and word lanes each return zero outside their own opcodes
  assign next_res    = byte_vec | word_vec;
  assign req_ready_o = !res_valid_o || res_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      res_data_o  <= '0;
    end else begin
      if (req_ready_o) res_valid_o <= req_valid_i;
      if (accept)      res_data_o  <= next_res;
    end
  end

  // R6: lanes never both drive a result for one opcode
  assert_lane_split_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_vec & word_vec) == '0);

  // R1: rounded byte average lies between the two inputs
  for (genvar k = 0; k < N_BYTES; k++) begin : g_chk_b
    assert_avg_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_AVG_B) |->
        ((byte_vec[k*BYTE_W +: BYTE_W] >= req_a_i[k*BYTE_W +: BYTE_W]) ||
         (byte_vec[k*BYTE_W +: BYTE_W] >= req_b_i[k*BYTE_W +: BYTE_W])));
  end

  // R5: high half of a 16x16 unsigned product never exceeds either factor
  for (genvar m = 0; m < N_WORDS; m++) begin : g_chk_w
    assert_mulh_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (op == OP_MULH_W) |->
        (word_vec[m*WORD_W +: WORD_W] <= req_a_i[m*WORD_W +: WORD_W]));
  end

  assert_accept_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> res_valid_o);

  assert_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && !res_ready_i) |=> (res_valid_o && $stable(res_data_o)));

  assert_drain_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (res_valid_o && res_ready_i && !req_valid_i) |=> !res_valid_o);
endmodule

// File: tb/pma_unit_tb.sv
module pma_unit_tb_top;
  localparam int W  = 16;
  localparam int NB = W / 8;
  localparam int NW = W / 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [2:0]   req_op = '0;
  logic [W-1:0] req_a = '0;
  logic [W-1:0] req_b = '0;
  logic         res_valid;
  logic         res_ready = 1'b1;
  logic [W-1:0] res_data;

  int n_vec  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  pma_unit #(.DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_op_i(req_op), .req_a_i(req_a), .req_b_i(req_b),
    .res_valid_o(res_valid), .res_ready_i(res_ready), .res_data_o(res_data)
  );

  function automatic logic [W-1:0] model(input int op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r = '0;
    for (int i = 0; i < NB; i++) begin
      int x = int'(a[i*8 +: 8]);
      int y = int'(b[i*8 +: 8]);
      int v = 0;
      if (op == 0) v = (x + y + 1) / 2;
      if (op == 3) v = (x > y) ? x : y;
      if (op == 5) v = (x < y) ? x : y;
      if (op == 0 || op == 3 || op == 5) r[i*8 +: 8] = v[7:0];
    end
    for (int j = 0; j < NW; j++) begin
      longint ux = longint'(a[j*16 +: 16]);
      longint uy = longint'(b[j*16 +: 16]);
      longint sx = (ux >= 32768) ? ux - 65536 : ux;
      longint sy = (uy >= 32768) ? uy - 65536 : uy;
      longint v = 0;
      if (op == 1) v = (ux + uy + 1) / 2;
      if (op == 2) v = (sx > sy) ? ux : uy;
      if (op == 4) v = (sx < sy) ? ux : uy;
      if (op == 6) v = (ux * uy) / 65536;
      if (op == 1 || op == 2 || op == 4 || op == 6) r[j*16 +: 16] = v[15:0];
    end
    return r;
  endfunction

  function automatic string req_tag(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2, 4: return "R3";
      3, 5: return "R4";
      6: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // one request, result sampled at the following negedge
  task automatic run(input int op, input logic [W-1:0] a, input logic [W-1:0] b, output logic [W-1:0] got);
    req_op = op[2:0]; req_a = a; req_b = b; req_valid = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check("R7 valid", {{(W-1){1'b0}}, res_valid}, {{(W-1){1'b0}}, 1'b1});
    got = res_data;
  endtask

  task automatic vec(input int op, input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] got;
    run(op, a, b, got);
    check(req_tag(op), got, model(op, a, b));
  endtask

  initial begin
    logic [W-1:0] got;
    logic [W-1:0] corner [8];
    logic [W-1:0] hold;
    corner = '{16'h0000, 16'hFFFF, 16'h7FFF, 16'h8000, 16'h0001, 16'h8001, 16'hFF00, 16'h00FF};

    @(negedge clk);
    check("R9 reset valid", {{(W-1){1'b0}}, res_valid}, '0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R9 idle valid", {{(W-1){1'b0}}, res_valid}, '0);
    check("R8 idle ready", {{(W-1){1'b0}}, req_ready}, {{(W-1){1'b0}}, 1'b1});

    // directed values
    run(0, 16'h0A0A, 16'h1514, got);
    check("R1 avg 10,20/10,21", got, 16'h100F);
    run(6, 16'd60000, 16'd32768, got);
    check("R5 60000*32768", got, 16'd30000);
    run(2, 16'h8000, 16'h7FFF, got);
    check("R3 signed max", got, 16'h7FFF);
    run(4, 16'h8000, 16'h7FFF, got);
    check("R3 signed min", got, 16'h8000);
    run(3, 16'h807F, 16'h7F80, got);
    check("R4 unsigned max", got, 16'h8080);
    run(7, 16'hFFFF, 16'hFFFF, got);
    check("R6 zero op", got, 16'h0000);

    // R4 clamp sweep: max with 16 then min with 235
    for (int v = 0; v < 256; v++) begin
      logic [W-1:0] t;
      int lo = v; int hi = 255 - v;
      int e0 = (lo < 16) ? 16 : (lo > 235 ? 235 : lo);
      int e1 = (hi < 16) ? 16 : (hi > 235 ? 235 : hi);
      run(3, {hi[7:0], lo[7:0]}, 16'h1010, t);
      run(5, t, 16'hEBEB, got);
      check("R4 clamp", got, {e1[7:0], e0[7:0]});
    end

    // word corner grid for every opcode
    for (int op = 0; op < 8; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          vec(op, corner[i], corner[j]);

    // byte sweep: lane 0 exhaustive in a, spread in b
    for (int op = 0; op < 8; op++)
      for (int x = 0; x < 256; x++)
        for (int y = 0; y < 256; y += 17)
          vec(op, {y[7:0] ^ 8'h5A, x[7:0]}, {x[7:0] ^ 8'hC3, y[7:0]});

    // back-to-back requests, result taken every cycle
    req_valid = 1'b1;
    for (int k = 0; k < 16; k++) begin
      req_op = 3'd1; req_a = 16'(k * 4097); req_b = 16'(k * 911);
      @(posedge clk); @(negedge clk);
      check("R7 streaming", res_data, model(1, 16'(k * 4097), 16'(k * 911)));
    end
    req_valid = 1'b0;
    @(negedge clk);
    check("R9 drain", {{(W-1){1'b0}}, res_valid}, '0);

    // stall: held result stays put, no acceptance
    res_ready = 1'b0;
    run(6, 16'hFFFF, 16'hFFFF, hold);
    check("R5 max product", hold, 16'hFFFE);
    req_op = 3'd0; req_a = 16'h1234; req_b = 16'h4321; req_valid = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R8 ready low", {{(W-1){1'b0}}, req_ready}, '0);
      check("R8 held data", res_data, hold);
    end
    res_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    req_valid = 1'b0;
    check("R8 after release", res_data, model(0, 16'h1234, 16'h4321));
    @(negedge clk);
    check("R9 empty", {{(W-1){1'b0}}, res_valid}, '0);

    // reset mid-result
    req_op = 3'd2; req_valid = 1'b1; @(negedge clk); req_valid = 1'b0;
    rst_n = 1'b0; @(negedge clk);
    check("R9 reset clears", {{(W-1){1'b0}}, res_valid}, '0);
    rst_n = 1'b1; @(negedge clk);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule